// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit CPU. Every clock it presents one 32-bit control word, one word per T-state, to a datapath that lies outside the block. A microstep counter and the opcode held in the instruction register together select the word from a microcode table. The first three steps of every instruction are a fetch that is the same for all opcodes. The steps after the fetch depend on the opcode.

Some control lines are active-low and the rest are active-high. Each table entry therefore lists only the lines it asserts. Per-line polarity inversion turns that list into the driven word, so a step that asserts nothing drives the idle word. The table does not store a length for each instruction. A comparator looks at the word planned for the next step. If that word is the idle word, the counter returns to step 0 and the next fetch starts. An instruction whose words never go idle runs for the full 20 T-states. A halt opcode freezes the sequencer until reset.

The interface carries no data stream. The opcode input and the control bus are plain level signals that are valid every cycle. There is no handshake and no back-pressure.

Top module: `useq_top`

## Requirements
- R1: The idle control word is 0x3E30C401. Bits 29, 28, 27, 26, 25, 21, 20, 15, 14, 10 and 0 are active-low and idle at 1. All other bits are active-high and idle at 0. Every driven word equals the idle word XOR the set of lines asserted in that step.
- R2: Steps 0 to 2 are a fetch for every opcode. Step 0 asserts PC-to-bus (bit 30) and MAR load (bit 29). Step 1 asserts memory read (bit 28) and instruction-register load (bit 27). Step 2 asserts PC increment (bit 31).
- R3: After the fetch, the counter returns to step 0 when the next step's word is idle. Step 3 is always driven. Opcode 0x00 and any opcode not listed in these requirements therefore take 4 T-states, and their step 3 drives the idle word.
- R4: Opcodes 1aaaddss (register to register) take 4 T-states. Step 3 asserts ALU enable (bit 22) and register-bank load (bit 10). It puts dd on bank select bits 9:8 and aaa on ALU function bits {7,17,16}. It asserts flag latch (bit 12) only when aaa is not 000.
- R5: Opcodes 010aaadd (register with immediate byte) take 8 T-states. The last step asserts B-register-to-bus (bit 23), bank load (bit 10) and flag latch (bit 12), with dd on bits 9:8.
- R6: Opcode 0x14 (direct load into R0) takes 9 T-states. Step 7 asserts address-pair-to-bus (bit 13) and MAR load (bit 29). Step 8 asserts memory read (bit 28) and bank load (bit 10).
- R7: Opcodes 0x20 to 0x23 (jump) take 8 T-states. Step 7 asserts address pair to bus (bit 13) and load PC (bit 18), with the low two opcode bits cc on condition bits 17:16. The cc codes are 00 = carry, 01 = non-zero, 10 = odd parity and 11 = always.
- R8: Opcode 0x30 (call) takes 14 T-states. Opcode 0x31 (return) takes 10 T-states.
- R9: The counter never exceeds step 19. Opcode 0x32 (stack fill), whose words never go idle, takes exactly 20 T-states.
- R10: Opcode 0x01 (halt) stops the counter at step 3. The block then drives the idle word on every cycle until reset.
- R11: An active-low reset, applied at any time, forces step 0 at once, so the fetch step-0 word is driven. Counting resumes at step 1 on the first clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 8 | Opcode held in the instruction register |
| ctrl_o | output | 32 | Control bus, one word per T-state |

## Verification
The bench runs one opcode from each encoding family: idle, undefined, register to register with flag update (ADD) and without it (MOV), immediate, direct load, two jump conditions, call, return, the never-idle stack fill, and halt. It measures each instruction's length as the spacing between fetch step-1 words. Matching lengths show that the idle comparator ends each sequence at the right step. Exact word checks at chosen steps separate a polarity or field-placement fault, such as the dd, aaa and cc bits and the flag latch that MOV must suppress, from a timing fault. Reset applied in the middle of an instruction and reset applied during halt show that the counter restarts from either state.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CW_W        = 32;
  localparam int OP_W        = 8;
  localparam int STEP_MAX    = 20;
  localparam int FETCH_STEPS = 3;
  localparam int STEP_W      = $clog2(STEP_MAX + 1);

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [OP_W-1:0]   op_t;
  typedef logic [STEP_W-1:0] step_t;

  // active-low lines: 29..25, 21, 20, 15, 14, 10, 0
  localparam cw_t IDLE_WORD = (cw_t'(1) << 29) | (cw_t'(1) << 28) | (cw_t'(1) << 27) |
                              (cw_t'(1) << 26) | (cw_t'(1) << 25) | (cw_t'(1) << 21) |
                              (cw_t'(1) << 20) | (cw_t'(1) << 15) | (cw_t'(1) << 14) |
                              (cw_t'(1) << 10) | cw_t'(1);

  localparam op_t OP_IDLE  = 8'h00;
  localparam op_t OP_HALT  = 8'h01;
  localparam op_t OP_LDDIR = 8'h14;
  localparam op_t OP_CALL  = 8'h30;
  localparam op_t OP_RET   = 8'h31;
  localparam op_t OP_FILL  = 8'h32;

  // line positions
  localparam int L_PCINC = 31, L_PCBUS = 30, L_MARLD = 29, L_MEMRD = 28, L_IRLD = 27;
  localparam int L_ALD = 25, L_ABUS = 24, L_BBUS = 23, L_ALUEN = 22, L_BLD = 21;
  localparam int L_MEMWR = 19, L_PCLD = 18, L_FN1 = 17, L_FN0 = 16;
  localparam int L_ADLO = 15, L_ADHI = 14, L_ADBUS = 13, L_FLG = 12, L_BKBUS = 11;
  localparam int L_BKLD = 10, L_SEL1 = 9, L_SEL0 = 8, L_FN2 = 7, L_SRCADR = 4;
  localparam int L_SPUP = 3, L_SPBUS = 2, L_SPCNT = 1;

  function automatic cw_t bt(input int n);
    return cw_t'(1) << n;
  endfunction

  function automatic cw_t fld_dst(input logic [1:0] dd);
    return (dd[1] ? bt(L_SEL1) : '0) | (dd[0] ? bt(L_SEL0) : '0);
  endfunction

  function automatic cw_t fld_alu(input logic [2:0] fn);
    return (fn[2] ? bt(L_FN2) : '0) | (fn[1] ? bt(L_FN1) : '0) | (fn[0] ? bt(L_FN0) : '0);
  endfunction

  // two-byte operand fetch from [PC++] into the address pair, steps e0..e3
  function automatic cw_t addr_fetch(input step_t e);
    case (e)
      step_t'(0): return bt(L_PCBUS) | bt(L_MARLD);
      step_t'(1): return bt(L_PCINC) | bt(L_MEMRD) | bt(L_ADLO);
      step_t'(2): return bt(L_PCBUS) | bt(L_MARLD);
      step_t'(3): return bt(L_PCINC) | bt(L_MEMRD) | bt(L_ADHI);
      default:    return '0;
    endcase
  endfunction

  // asserted-line set of execute step e (e = step - FETCH_STEPS)
  function automatic cw_t exec_mask(input op_t op, input step_t e);
    cw_t m = '0;
    if (op[7]) begin
      if (e == step_t'(0))
        m = bt(L_ALUEN) | bt(L_BKLD) | fld_dst(op[3:2]) | fld_alu(op[6:4]) |
            ((op[6:4] != 3'b000) ? bt(L_FLG) : '0);
    end else if (op[7:5] == 3'b010) begin
      case (e)
        step_t'(0): m = bt(L_BKBUS) | bt(L_ALD) | fld_dst(op[1:0]);
        step_t'(1): m = bt(L_PCBUS) | bt(L_MARLD);
        step_t'(2): m = bt(L_PCINC) | bt(L_MEMRD) | bt(L_BLD);
        step_t'(3): m = bt(L_ALUEN) | fld_alu(op[4:2]);
        step_t'(4): m = bt(L_BBUS) | bt(L_BKLD) | bt(L_FLG) | fld_dst(op[1:0]);
        default:    m = '0;
      endcase
    end else if (op == OP_LDDIR) begin
      case (e)
        step_t'(4): m = bt(L_ADBUS) | bt(L_MARLD);
        step_t'(5): m = bt(L_MEMRD) | bt(L_BKLD);
        default:    m = addr_fetch(e);
      endcase
    end else if (op[7:2] == 6'b001000) begin
      if (e == step_t'(4))
        m = bt(L_ADBUS) | bt(L_PCLD) | (op[1] ? bt(L_FN1) : '0) | (op[0] ? bt(L_FN0) : '0);
      else
        m = addr_fetch(e);
    end else if (op == OP_CALL) begin
      case (e)
        step_t'(4):  m = bt(L_SPCNT);
        step_t'(5):  m = bt(L_SPBUS) | bt(L_MARLD);
        step_t'(6):  m = bt(L_PCBUS) | bt(L_SRCADR) | bt(L_ALD);
        step_t'(7):  m = bt(L_ABUS) | bt(L_MEMWR);
        step_t'(8):  m = bt(L_SPCNT);
        step_t'(9):  m = bt(L_SPBUS) | bt(L_MARLD);
        step_t'(10): m = bt(L_BBUS) | bt(L_MEMWR) | bt(L_ADBUS) | bt(L_PCLD) |
                         bt(L_FN1) | bt(L_FN0);
        default:     m = addr_fetch(e);
      endcase
    end else if (op == OP_RET) begin
      case (e)
        step_t'(0): m = bt(L_SPBUS) | bt(L_MARLD);
        step_t'(1): m = bt(L_MEMRD) | bt(L_ADLO);
        step_t'(2): m = bt(L_SPCNT) | bt(L_SPUP);
        step_t'(3): m = bt(L_SPBUS) | bt(L_MARLD);
        step_t'(4): m = bt(L_MEMRD) | bt(L_ADHI);
        step_t'(5): m = bt(L_SPCNT) | bt(L_SPUP);
        step_t'(6): m = bt(L_ADBUS) | bt(L_PCLD) | bt(L_FN1) | bt(L_FN0);
        default:    m = '0;
      endcase
    end else if (op == OP_FILL) begin
      m = bt(L_SPBUS) | bt(L_MEMWR) | bt(L_SPCNT);
    end
    return m;
  endfunction

  function automatic cw_t act_mask(input op_t op, input step_t st);
    case (st)
      step_t'(0): return bt(L_PCBUS) | bt(L_MARLD);
      step_t'(1): return bt(L_MEMRD) | bt(L_IRLD);
      step_t'(2): return bt(L_PCINC);
      default:    return exec_mask(op, st - step_t'(FETCH_STEPS));
    endcase
  endfunction
endpackage

// File: rtl/useq_ucode_rom.sv
module useq_ucode_rom
  import useq_pkg::*;
#(
  parameter int  W    = CW_W,
  parameter cw_t IDLE = IDLE_WORD
) (
  input  op_t         op_i,
  input  step_t       step_i,
  output logic [W-1:0] word_o
);
  cw_t act;
  assign act = act_mask(op_i, step_i);

  for (genvar i = 0; i < W; i++) begin : g_pol
    if (IDLE[i]) begin : g_lo
      assign word_o[i] = ~act[i];
    end else begin : g_hi
      assign word_o[i] = act[i];
    end
  end
endmodule

// File: rtl/useq_idle_cmp.sv
module useq_idle_cmp
  import useq_pkg::*;
#(
  parameter int  W    = CW_W,
  parameter cw_t IDLE = IDLE_WORD
) (
  input  logic [W-1:0] word_i,
  output logic         idle_o
);
  assign idle_o = (word_i == IDLE[W-1:0]);
endmodule

// File: rtl/useq_step_ctr.sv
module useq_step_ctr
  import useq_pkg::*;
#(
  parameter int SMAX = STEP_MAX
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold_i,
  input  logic  end_i,
  output step_t step_o
);
  localparam step_t LAST = step_t'(SMAX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          step_o <= '0;
    else if (hold_i)                     step_o <= step_o;
    else if (end_i || step_o == LAST)    step_o <= '0;
    else                                 step_o <= step_o + step_t'(1);
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_o < step_t'(SMAX)); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(step_o)); // R10
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode_i,
  output logic [CW_W-1:0] ctrl_o
);
  localparam step_t EXEC0 = step_t'(FETCH_STEPS);

  step_t step_q;
  step_t step_nx;
  cw_t   word_nx;
  logic  nx_idle;
  logic  halt_hold;
  logic  end_now;

  assign step_nx = step_q + step_t'(1);

  useq_ucode_rom u_rom_cur (.op_i(opcode_i), .step_i(step_q),  .word_o(ctrl_o));
  useq_ucode_rom u_rom_nxt (.op_i(opcode_i), .step_i(step_nx), .word_o(word_nx));

  useq_idle_cmp u_cmp (.word_i(word_nx), .idle_o(nx_idle));

  assign halt_hold = (opcode_i == OP_HALT) && (step_q == EXEC0);
  assign end_now   = (step_q >= EXEC0) && nx_idle;

  useq_step_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .hold_i(halt_hold), .end_i(end_now), .step_o(step_q)
  );

  AST_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= EXEC0 && nx_idle && !halt_hold) |=> (step_q == '0)); // R3
  AST_FETCH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q < EXEC0) |=> (step_q == $past(step_q) + step_t'(1))); // R2
  AST_FETCH_IRLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == step_t'(1)) |-> !ctrl_o[L_IRLD]); // R2
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hold |-> (ctrl_o == IDLE_WORD)); // R10
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb_top;
  localparam logic [31:0] NOPW = 32'h3E30C401;
  localparam logic [31:0] F0W  = NOPW ^ ((32'd1 << 30) | (32'd1 << 29));
  localparam logic [31:0] F1W  = NOPW ^ ((32'd1 << 28) | (32'd1 << 27));
  localparam logic [31:0] F2W  = NOPW ^ (32'd1 << 31);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [31:0] ctrl_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [31:0] w [0:47];
  int len;

  useq_top dut_i (.clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .ctrl_o(ctrl_o));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // called at negedge during step 1; returns at step 1 of the next instruction
  task automatic run_op(input logic [7:0] op);
    opcode_i = op;
    len = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      w[n] = ctrl_o;
      len = n;
      if (ctrl_o == F1W) break;
    end
  endtask

  function automatic logic [31:0] fl(input logic [31:0] m);
    return NOPW ^ m;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ctrl_o == F0W, "R11 reset word", ctrl_o, F0W);
    chk(ctrl_o == (NOPW ^ 32'h6000_0000), "R1 fetch0 polarity", ctrl_o, NOPW ^ 32'h6000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_o == F1W, "R2 fetch step1", ctrl_o, F1W);
  endtask

  task automatic t_idle();
    run_op(8'h00);
    chk(w[1] == F2W, "R2 fetch step2", w[1], F2W);
    chk(w[2] == NOPW, "R1 idle step3 word", w[2], NOPW);
    chk(len == 4, "R3 idle opcode length", len, 4);
    run_op(8'h77);
    chk(len == 4, "R3 undefined opcode length", len, 4);
  endtask

  task automatic t_regreg();
    run_op(8'h99); // ADD, dd=10
    chk(len == 4, "R4 add length", len, 4);
    chk(w[2] == fl((32'd1<<22)|(32'd1<<10)|(32'd1<<9)|(32'd1<<16)|(32'd1<<12)),
        "R4 add word", w[2], fl((32'd1<<22)|(32'd1<<10)|(32'd1<<9)|(32'd1<<16)|(32'd1<<12)));
    run_op(8'h8D); // MOV, dd=11, no flag latch
    chk(w[2] == fl((32'd1<<22)|(32'd1<<10)|(32'd1<<9)|(32'd1<<8)),
        "R4 mov word", w[2], fl((32'd1<<22)|(32'd1<<10)|(32'd1<<9)|(32'd1<<8)));
  endtask

  task automatic t_imm();
    run_op(8'h4E); // aaa=011 dd=10
    chk(len == 8, "R5 immediate length", len, 8);
    chk(w[6] == fl((32'd1<<23)|(32'd1<<10)|(32'd1<<12)|(32'd1<<9)),
        "R5 immediate last word", w[6], fl((32'd1<<23)|(32'd1<<10)|(32'd1<<12)|(32'd1<<9)));
  endtask

  task automatic t_lddir();
    run_op(8'h14);
    chk(len == 9, "R6 direct load length", len, 9);
    chk(w[6] == fl((32'd1<<13)|(32'd1<<29)), "R6 step7 word", w[6], fl((32'd1<<13)|(32'd1<<29)));
    chk(w[7] == fl((32'd1<<28)|(32'd1<<10)), "R6 step8 word", w[7], fl((32'd1<<28)|(32'd1<<10)));
  endtask

  task automatic t_jump();
    run_op(8'h22);
    chk(len == 8, "R7 jump length", len, 8);
    chk(w[6] == fl((32'd1<<13)|(32'd1<<18)|(32'd1<<17)), "R7 jump parity word", w[6],
        fl((32'd1<<13)|(32'd1<<18)|(32'd1<<17)));
    run_op(8'h21);
    chk(w[6] == fl((32'd1<<13)|(32'd1<<18)|(32'd1<<16)), "R7 jump nonzero word", w[6],
        fl((32'd1<<13)|(32'd1<<18)|(32'd1<<16)));
  endtask

  task automatic t_callret();
    run_op(8'h30);
    chk(len == 14, "R8 call length", len, 14);
    run_op(8'h31);
    chk(len == 10, "R8 return length", len, 10);
  endtask

  task automatic t_fill();
    run_op(8'h32);
    chk(len == 20, "R9 max length", len, 20);
  endtask

  task automatic t_halt();
    bit all_idle;
    opcode_i = 8'h01;
    all_idle = 1'b1;
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (n >= 2 && ctrl_o != NOPW) all_idle = 1'b0;
    end
    chk(all_idle, "R10 halt holds idle word", ctrl_o, NOPW);
    rst_n = 1'b0;
    #1;
    chk(ctrl_o == F0W, "R11 reset leaves halt", ctrl_o, F0W);
    opcode_i = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_o == F1W, "R11 resume after halt", ctrl_o, F1W);
  endtask

  task automatic t_midreset();
    opcode_i = 8'h14;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ctrl_o == F0W, "R11 reset mid instruction", ctrl_o, F0W);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_o == F1W, "R11 restart fetch", ctrl_o, F1W);
    run_op(8'h00);
    chk(len == 4, "R3 after reset", len, 4);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_regreg();
    t_imm();
    t_lddir();
    t_jump();
    t_callret();
    t_fill();
    t_midreset();
    t_halt();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule